// File: doc/BRIEF.md
# Serial DAC Write Interface Controller

This block is the digital front end of a single-channel 16-bit voltage-output DAC. A host drives three wires: an active-low frame select, a serial clock and a serial data line. The block takes in a 24-bit command word, most significant bit first, on falling serial-clock edges. When the frame completes, it loads a 16-bit output code and a 2-bit power mode. From the power mode it drives the control lines of the output stage: amplifier enable, three-state, and the 1 kΩ and 100 kΩ pulldowns to ground.

The serial pins are asynchronous to the block clock. They pass through a synchronizer and are oversampled, so each serial level must last at least two block-clock periods. A frame that ends early is dropped. A frame whose top byte is all ones is a software reset. Once such a frame has started, an early end does not stop it. A one-cycle strobe marks every change of the code or mode register.

Top module: `dac_ser_if`

## Requirements
- R1: After reset the code is 0x8000, the mode is 2'b00, amp_en_o is 1, hiz_o, pd_100k_o and pd_1k_o are 0, and upd_o is 0.
- R2: A falling edge on sync_ni starts a frame. Each falling edge of sclk_i while sync_ni is low shifts in one bit from sdi_i. The first bit taken is word bit 23.
- R3: On the 24th falling sclk_i edge of a frame, code_o takes word bits 15:0 and mode_o takes word bits 17:16. Word bits 23:18 are ignored unless they form part of the reset pattern of R8.
- R4: Falling sclk_i edges after the 24th have no effect while sync_ni stays low, and nothing is taken in again until sync_ni goes high and then low.
- R5: If sync_ni rises before the 24th falling edge of a frame that is not a reset frame, code_o and mode_o keep their values and no strobe is raised. The next frame starts from an empty shift register.
- R6: Mode 2'b00 asserts only amp_en_o. Mode 2'b01 asserts only hiz_o. Mode 2'b10 asserts only pd_100k_o. Mode 2'b11 asserts only pd_1k_o.
- R7: Entering or leaving a power-down mode loads the code from the same word and has no other effect on the code register. A frame that repeats the current code keeps that code across the mode change.
- R8: A frame whose first eight bits (word bits 23:16) are all ones is a software reset, whatever its later bits. At its 24th falling edge, code_o returns to 0x8000 and mode_o returns to 2'b00.
- R9: Once the eighth bit of a reset frame has been taken, an early rise of sync_ni still performs the software reset, at that rise.
- R10: upd_o is high for exactly one cycle when an accepted write or reset changes code_o or mode_o. It stays low for a write or reset that leaves both unchanged.
- R11: Falling sclk_i edges while sync_ni is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| sdi_i | input | 1 | Serial data, MSB first |
| code_o | output | CODE_W | Stored DAC code |
| mode_o | output | 2 | Stored power mode |
| upd_o | output | 1 | One-cycle strobe on a change of code or mode |
| amp_en_o | output | 1 | Output amplifier enabled (normal operation) |
| hiz_o | output | 1 | Output three-stated |
| pd_100k_o | output | 1 | Output pulled to ground through 100 kΩ |
| pd_1k_o | output | 1 | Output pulled to ground through 1 kΩ |

## Verification
A pin change first seen at rising clock edge j is acted on at edge j+SYNC_STAGES. The code, mode, control lines and strobe all change on that edge. With the default two synchronizer stages, that is the third rising edge that sees the new level. The bench model pushes the pin values into a queue on every rising edge. It acts on the entry SYNC_STAGES places back. It compares every output at the following falling edge, so the model and the block agree on the exact cycle of each update. Directed checks run only after the frame select has been high for eight cycles, well past that delay. They compare the registers against fixed values and the number of strobes against the number of changes expected.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_PD100K = 2'b10,
    MODE_PD1K   = 2'b11
  } pwr_mode_e;

  localparam int unsigned MODE_W   = 2;
  localparam int unsigned N_MODES  = 1 << MODE_W;
endpackage

// File: rtl/dac_ser_sync.sv
module dac_ser_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dac_ser_frame.sv
module dac_ser_frame #(
  parameter int unsigned FRAME_W  = 24,
  parameter int unsigned PREFIX_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_n_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               cmd_wr_o,
  output logic               cmd_rst_o,
  output logic [FRAME_W-1:0] cmd_word_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] PFX_IDX  = CNT_W'(PREFIX_W - 1);

  logic               sync_p, sclk_p;
  logic               active, armed;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] sr;

  logic sync_fall, sync_rise, clk_fall, shift_en, last;
  logic [FRAME_W-1:0] nxt_word;

  always_comb begin
    sync_fall = sync_p & ~sync_n_i;
    sync_rise = ~sync_p & sync_n_i;
    clk_fall  = sclk_p & ~sclk_i;
    shift_en  = active & ~sync_rise & ~sync_fall & clk_fall;
    nxt_word  = {sr, sdi_i};
    last      = shift_en && (cnt == LAST_IDX);
  end

  // armed reset frame completes at its last bit or at an early sync rise
  assign cmd_wr_o   = last & ~armed;
  assign cmd_rst_o  = (last & armed) | (active & sync_rise & armed);
  assign cmd_word_o = nxt_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_p <= 1'b1;
      sclk_p <= 1'b0;
      active <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      sync_p <= sync_n_i;
      sclk_p <= sclk_i;
      if (sync_fall) begin
        active <= 1'b1;
        armed  <= 1'b0;
        cnt    <= '0;
        sr     <= '0;
      end else if (active && sync_rise) begin
        active <= 1'b0;
        armed  <= 1'b0;
        cnt    <= '0;
        sr     <= '0;
      end else if (shift_en) begin
        sr  <= nxt_word[FRAME_W-2:0];
        cnt <= cnt + 1'b1;
        if (cnt == PFX_IDX && &nxt_word[PREFIX_W-1:0]) armed <= 1'b1;
        if (last) begin
          active <= 1'b0;
          armed  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dac_ser_regs.sv
module dac_ser_regs #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              srst_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              upd_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic              fire, chg;
  logic [CODE_W-1:0] nxt_code;
  logic [MODE_W-1:0] nxt_mode;

  always_comb begin
    fire     = wr_i | srst_i;
    nxt_code = srst_i ? MID : wr_code_i;
    nxt_mode = srst_i ? '0  : wr_mode_i;
    chg      = fire && ((nxt_code != code_o) || (nxt_mode != mode_o));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= MID;
      mode_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= chg;
      if (fire) begin
        code_o <= nxt_code;
        mode_o <= nxt_mode;
      end
    end
  end
endmodule

// File: rtl/dac_ser_outctl.sv
module dac_ser_outctl
  import dac_ser_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              amp_en_o,
  output logic              hiz_o,
  output logic              pd_100k_o,
  output logic              pd_1k_o
);
  logic [N_MODES-1:0] sel;

  for (genvar g = 0; g < N_MODES; g++) begin : g_dec
    assign sel[g] = (mode_i == MODE_W'(g));
  end

  assign amp_en_o  = sel[MODE_RUN];
  assign hiz_o     = sel[MODE_HIZ];
  assign pd_100k_o = sel[MODE_PD100K];
  assign pd_1k_o   = sel[MODE_PD1K];
endmodule

// File: rtl/dac_ser_if.sv
module dac_ser_if
  import dac_ser_pkg::*;
#(
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned PAD_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        mode_o,
  output logic              upd_o,
  output logic              amp_en_o,
  output logic              hiz_o,
  output logic              pd_100k_o,
  output logic              pd_1k_o
);
  localparam int unsigned PREFIX_W = PAD_W + MODE_W;
  localparam int unsigned FRAME_W  = PREFIX_W + CODE_W;

  logic [2:0]         pins_s;
  logic               cmd_wr, cmd_rst;
  logic [FRAME_W-1:0] cmd_word;

  dac_ser_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sync_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  dac_ser_frame #(.FRAME_W(FRAME_W), .PREFIX_W(PREFIX_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_n_i  (pins_s[2]),
    .sclk_i    (pins_s[1]),
    .sdi_i     (pins_s[0]),
    .cmd_wr_o  (cmd_wr),
    .cmd_rst_o (cmd_rst),
    .cmd_word_o(cmd_word)
  );

  dac_ser_regs #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cmd_wr),
    .srst_i   (cmd_rst),
    .wr_code_i(cmd_word[CODE_W-1:0]),
    .wr_mode_i(cmd_word[CODE_W +: MODE_W]),
    .code_o   (code_o),
    .mode_o   (mode_o),
    .upd_o    (upd_o)
  );

  dac_ser_outctl u_outctl (
    .mode_i   (mode_o),
    .amp_en_o (amp_en_o),
    .hiz_o    (hiz_o),
    .pd_100k_o(pd_100k_o),
    .pd_1k_o  (pd_1k_o)
  );
endmodule

// File: rtl/dac_ser_if_chk.sv
module dac_ser_if_chk #(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic              cmd_rst_i,
  input logic [CODE_W-1:0] cmd_code_i,
  input logic [CODE_W-1:0] code_o,
  input logic [1:0]        mode_o,
  input logic              upd_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr_i || cmd_rst_i) |=> ($stable(code_o) && $stable(mode_o))); // R5

  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !cmd_rst_i) |=> (code_o == $past(cmd_code_i))); // R3

  AST_SWRST_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> (code_o == MID && mode_o == 2'b00)); // R8

  AST_CHANGE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o) || mode_o != $past(mode_o)) |-> upd_o); // R10

  AST_STROBE_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (code_o != $past(code_o) || mode_o != $past(mode_o))); // R10

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o); // R10
endmodule

bind dac_ser_if dac_ser_if_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_wr_i  (cmd_wr),
  .cmd_rst_i (cmd_rst),
  .cmd_code_i(cmd_word[CODE_W-1:0]),
  .code_o    (code_o),
  .mode_o    (mode_o),
  .upd_o     (upd_o)
);

// File: tb/tb_dac_ser_if.sv
`timescale 1ns/1ps
module tb_dac_ser_if;
  localparam int S    = 2;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] code;
  logic [1:0]  mode;
  logic upd, amp_en, hiz, pd100k, pd1k;

  int n_chk = 0, n_fail = 0, n_upd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_ser_if #(.CODE_W(16), .PAD_W(6), .SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code), .mode_o(mode), .upd_o(upd), .amp_en_o(amp_en), .hiz_o(hiz),
    .pd_100k_o(pd100k), .pd_1k_o(pd1k)
  );

  // behavioural reference: pins delayed by S edges via a queue
  logic [2:0] hist[$];
  int m_code, m_mode, m_cnt;
  bit m_upd, m_act, m_armed;
  int unsigned m_word;

  task automatic m_apply(input int c, input int md);
    m_upd  = (c != m_code) || (md != m_mode);
    m_code = c;
    m_mode = md;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i <= S; i++) hist.push_back(3'b100);
      m_code = 32'h8000; m_mode = 0; m_upd = 0;
      m_act = 0; m_armed = 0; m_cnt = 0; m_word = 0;
    end else begin
      logic [2:0] cur, prv;
      hist.push_back({sync_n, sclk, sdi});
      while (hist.size() > S + 2) void'(hist.pop_front());
      cur = hist[hist.size()-1-S];
      prv = hist[hist.size()-2-S];
      m_upd = 0;
      if (prv[2] && !cur[2]) begin
        m_act = 1; m_cnt = 0; m_word = 0; m_armed = 0;
      end else if (m_act && !prv[2] && cur[2]) begin
        if (m_armed) m_apply(32'h8000, 0);
        m_act = 0; m_armed = 0;
      end else if (m_act && prv[1] && !cur[1]) begin
        m_word = ((m_word << 1) | cur[0]) & 32'hFF_FFFF;
        m_cnt++;
        if (m_cnt == 8 && (m_word & 8'hFF) == 8'hFF) m_armed = 1;
        if (m_cnt == 24) begin
          if (m_armed) m_apply(32'h8000, 0);
          else m_apply(m_word & 16'hFFFF, (m_word >> 16) & 3);
          m_act = 0; m_armed = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (upd) n_upd++;
      chk("R3 code vs model", int'(code), m_code);
      chk("R3 mode vs model", int'(mode), m_mode);
      chk("R10 strobe vs model", int'(upd), int'(m_upd));
      chk("R6 controls vs model", int'({amp_en, hiz, pd100k, pd1k}),
          int'(4'b1000 >> m_mode));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, input int extra);
    sync_n = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdi = w[23-i];
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
    end
    for (int i = 0; i < extra; i++) begin
      sclk = 1'b1; sdi = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
    end
    sync_n = 1'b1; sdi = 1'b0;
    wait_cyc(8);
    #1;
  endtask

  task automatic expect_state(input string tag, input int c, input int md, input int nu0, input int dn);
    chk({tag, " code"}, int'(code), c);
    chk({tag, " mode"}, int'(mode), md);
    chk({tag, " strobes"}, n_upd - nu0, dn);
  endtask

  initial begin
    int nu;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2); #1;
    // R1 reset state
    chk("R1 code", int'(code), 32'h8000);
    chk("R1 mode", int'(mode), 0);
    chk("R1 ctrl", int'({amp_en, hiz, pd100k, pd1k}), 4'b1000);
    chk("R1 upd", int'(upd), 0);

    // R11 serial clocks while frame select high
    nu = n_upd;
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1; sdi = 1'b1; wait_cyc(HALF); sclk = 1'b0; wait_cyc(HALF);
    end
    sdi = 1'b0; wait_cyc(6); #1;
    expect_state("R11 sclk ignored", 32'h8000, 0, nu, 0);

    // R2 R3 plain write, MSB first
    nu = n_upd;
    xfer(24'h00_1234, 24, 0);
    expect_state("R2 R3 write", 32'h1234, 0, nu, 1);

    // R6 100k pulldown mode
    nu = n_upd;
    xfer(24'h02_ABCD, 24, 0);
    expect_state("R6 pd100k", 32'hABCD, 2, nu, 1);
    chk("R6 pd100k ctrl", int'({amp_en, hiz, pd100k, pd1k}), 4'b0010);

    // R6 R7 three-state with same code
    nu = n_upd;
    xfer(24'h01_ABCD, 24, 0);
    expect_state("R7 hiz keeps code", 32'hABCD, 1, nu, 1);
    chk("R6 hiz ctrl", int'({amp_en, hiz, pd100k, pd1k}), 4'b0100);

    // R6 1k pulldown, then back to normal
    xfer(24'h03_0F0F, 24, 0);
    chk("R6 pd1k ctrl", int'({amp_en, hiz, pd100k, pd1k}), 4'b0001);
    nu = n_upd;
    xfer(24'h00_0F0F, 24, 0);
    expect_state("R7 leave pd", 32'h0F0F, 0, nu, 1);
    chk("R6 run ctrl", int'({amp_en, hiz, pd100k, pd1k}), 4'b1000);

    // R10 same-value write: no strobe
    nu = n_upd;
    xfer(24'h00_0F0F, 24, 0);
    expect_state("R10 no change", 32'h0F0F, 0, nu, 0);

    // R5 abort after 20 bits and after 23 bits
    nu = n_upd;
    xfer(24'h02_5555, 20, 0);
    expect_state("R5 abort 20", 32'h0F0F, 0, nu, 0);
    xfer(24'h03_5555, 23, 0);
    expect_state("R5 abort 23", 32'h0F0F, 0, nu, 0);
    xfer(24'h00_2468, 24, 0);
    expect_state("R5 clean restart", 32'h2468, 0, nu, 1);

    // R4 extra edges after the 24th
    nu = n_upd;
    xfer(24'h00_7777, 24, 8);
    expect_state("R4 extra ignored", 32'h7777, 0, nu, 1);

    // R3 nonzero pad bits ignored
    nu = n_upd;
    xfer(24'hA8_4242, 24, 0);
    expect_state("R3 pad ignored", 32'h4242, 0, nu, 1);

    // R8 top byte not all ones: ordinary write
    nu = n_upd;
    xfer(24'h03_FFFF, 24, 0);
    expect_state("R8 not reset", 32'hFFFF, 3, nu, 1);

    // R8 full all-ones reset
    nu = n_upd;
    xfer(24'hFF_FFFF, 24, 0);
    expect_state("R8 soft reset", 32'h8000, 0, nu, 1);

    // R8 reset prefix with arbitrary tail
    xfer(24'h01_0001, 24, 0);
    nu = n_upd;
    xfer(24'hFF_1357, 24, 0);
    expect_state("R8 prefix reset", 32'h8000, 0, nu, 1);

    // R9 armed reset cut short still resets
    xfer(24'h03_0001, 24, 0);
    nu = n_upd;
    xfer(24'hFF_FFFF, 12, 0);
    expect_state("R9 uninterruptible", 32'h8000, 0, nu, 1);

    // R5 abort at 7 bits of ones: not yet armed
    xfer(24'h02_0042, 24, 0);
    nu = n_upd;
    xfer(24'hFF_FFFF, 7, 0);
    expect_state("R5 unarmed abort", 32'h0042, 2, nu, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule